// File: doc/BRIEF.md
# Packet Classify, Drop and Steer Pipeline

This block sorts a stream of received packet records without any per-packet help from the host. Each packet enters as a sequence of 32-bit words framed by start and end flags, with the number of the line port it arrived on. The opening words of the packet are kept in a window register. Once that window is complete, the block works out three things at the same time: the results of eight mask-and-compare filters, and two parity-based load-balancing bits. These ten bits and the port number form the address of a programmable classification table. The table entry gives a color, a drop flag and the number of an output stream.

While the decision is being made, the packet waits in an internal word FIFO. A dropped packet is drained from the FIFO and produces nothing at the output. A kept packet leaves with its color written into a fixed header field, and the stream number is shown beside every one of its words. Backpressure at the output makes the block stall its input and never lose a word.

Configuration arrives on a synchronous write port, one word per cycle. Through this port, software loads the filter values, the filter masks and the table entries.

Top module: `pkt_classify`

## Requirements
- R1: After reset, out_valid_o is 0 and in_ready_o is 1.
- R2: Filter f is true when, for every window word k from 0 to 7, (word AND mask[f][k]) equals (value[f][k] AND mask[f][k]). Writes use cfg_sel_i=1 for value words and cfg_sel_i=2 for mask words, with cfg_addr_i = f*8+k. All masks are zero after reset.
- R3: For a packet shorter than eight words, the missing window words are taken as zero by the filters and by the load-balance bits.
- R4: Load-balance bit 0 is the XOR of all bits of words 3 and 4. Load-balance bit 1 is the XOR of all bits of word 5. Word 0 is the start word.
- R5: The table index is {port[1:0], lb1, lb0, filter[7:0]}: the port is in bits 11:10, and filter f is in bit f. A table write uses cfg_sel_i=3 and cfg_addr_i=index. Its data bits 13:0 are the color, bit 14 is the drop flag and bits 17:16 are the stream.
- R6: A packet whose entry has the drop flag set produces no output beat. The packets around it are unaffected.
- R7: In a kept packet, bits 15:0 of word 1 are replaced by the color, zero-extended. Every other bit and word passes unchanged. A one-word packet passes unchanged.
- R8: out_stream_o equals the entry's stream on every beat of a kept packet.
- R9: Under output backpressure, no word is lost or reordered. While out_valid_o is high and out_ready_i is low, the output holds steady. A full FIFO drops in_ready_o.
- R10: A packet is classified with the configuration present once its window completes. A table write made after the packet's start, but before word 7 has been accepted, applies to that packet.
- R11: out_sop_o marks the first beat of each output packet and out_eop_o marks the last. The output length equals the input length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input word valid |
| in_ready_o | output | 1 | Input word accepted when high with valid |
| in_sop_i | input | 1 | First word of a packet |
| in_eop_i | input | 1 | Last word of a packet |
| in_data_i | input | 32 | Input word |
| in_port_i | input | 2 | Arrival port, sampled on the first word |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Downstream accepts output word |
| out_sop_o | output | 1 | First output word of a packet |
| out_eop_o | output | 1 | Last output word of a packet |
| out_data_o | output | 32 | Output word with the color inserted |
| out_stream_o | output | 2 | Destination receive stream |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Write target: 1 filter value, 2 filter mask, 3 table |
| cfg_addr_i | input | 12 | Filter word or table index |
| cfg_wdata_i | input | 32 | Write data |

## Verification
The bench goes after short packets. There, a design that does not zero-pad the window would let stale words from the previous packet set filter hits or parity bits, and so select the wrong table entry and color. It also sends one-word and two-word packets, which catch header insertion landing on the wrong word. It mixes dropped packets with kept ones, so that a design leaking drop-flagged words, or losing its place in the FIFO afterwards, breaks the expected output sequence. It holds the output stalled long enough to fill the FIFO. A table entry is also rewritten in the middle of a packet's window: a design that reads the table at the start word instead of at window completion would show the old color.

// File: rtl/pcls_pkg.sv
package pcls_pkg;
  typedef enum logic [1:0] {
    CFG_NONE  = 2'd0,
    CFG_FVAL  = 2'd1,
    CFG_FMASK = 2'd2,
    CFG_TABLE = 2'd3
  } cfg_sel_e;

  typedef enum logic [1:0] {
    ST_COLLECT = 2'd0,
    ST_DECIDE  = 2'd1,
    ST_FORWARD = 2'd2
  } state_e;
endpackage

// File: rtl/pcls_fifo.sv
module pcls_fifo #(
  parameter int W     = 34,
  parameter int DEPTH = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;

  assign full_o  = (cnt_q == (AW+1)'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign rdata_o = mem_q[rp_q];

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
      if (pop_i)  rp_q <= (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/pcls_window.sv
module pcls_window #(
  parameter int DW  = 32,
  parameter int WIN = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    beat_i,
  input  logic                    sop_i,
  input  logic                    eop_i,
  input  logic [DW-1:0]           data_i,
  output logic [WIN-1:0][DW-1:0]  win_o,
  output logic                    done_o
);
  localparam int CW = $clog2(WIN+1);

  logic [CW-1:0] cnt_q, slot;
  logic [WIN-1:0][DW-1:0] win_q;

  assign slot   = sop_i ? '0 : cnt_q;
  assign done_o = beat_i && (eop_i || slot == CW'(WIN-1));
  assign win_o  = win_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      win_q <= '0;
    end else if (beat_i) begin
      cnt_q <= (slot < CW'(WIN)) ? slot + 1'b1 : slot;
      for (int k = 0; k < WIN; k++) begin
        if (CW'(k) == slot) win_q[k] <= data_i;
        else if (sop_i)     win_q[k] <= '0;  // zero-pad short packets
      end
    end
  end
endmodule

// File: rtl/pcls_match.sv
module pcls_match #(
  parameter int DW     = 32,
  parameter int WIN    = 8,
  parameter int NF     = 8,
  parameter int PORT_W = 2,
  parameter int LB0_A  = 3,
  parameter int LB0_B  = 4,
  parameter int LB1_A  = 5,
  localparam int FA_W  = $clog2(NF) + $clog2(WIN),
  localparam int IDX_W = PORT_W + 2 + NF
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic                   is_mask_i,
  input  logic [FA_W-1:0]        addr_i,
  input  logic [DW-1:0]          wdata_i,
  input  logic [WIN-1:0][DW-1:0] win_i,
  input  logic [PORT_W-1:0]      port_i,
  output logic [IDX_W-1:0]       idx_o
);
  localparam int WS_W = $clog2(WIN);
  localparam int FS_W = $clog2(NF);

  logic [NF-1:0][WIN-1:0][DW-1:0] fval_q, fmask_q;
  logic [NF-1:0][WIN-1:0]         wok;
  logic [NF-1:0]                  hit;
  logic [FS_W-1:0]                fsel;
  logic [WS_W-1:0]                wsel;
  logic                           lb0, lb1;

  assign fsel = addr_i[FA_W-1 -: FS_W];
  assign wsel = addr_i[WS_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fval_q  <= '0;
      fmask_q <= '0;
    end else if (we_i) begin
      if (is_mask_i) fmask_q[fsel][wsel] <= wdata_i;
      else           fval_q[fsel][wsel]  <= wdata_i;
    end
  end

  for (genvar f = 0; f < NF; f++) begin : g_filt
    for (genvar k = 0; k < WIN; k++) begin : g_word
      assign wok[f][k] = ((win_i[k] ^ fval_q[f][k]) & fmask_q[f][k]) == '0;
    end
    assign hit[f] = &wok[f];
  end

  assign lb0   = ^{win_i[LB0_A], win_i[LB0_B]};
  assign lb1   = ^win_i[LB1_A];
  assign idx_o = {port_i, lb1, lb0, hit};
endmodule

// File: rtl/pcls_table.sv
module pcls_table #(
  parameter int IDX_W = 12,
  parameter int ENT_W = 17
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [ENT_W-1:0] wdata_i,
  input  logic [IDX_W-1:0] raddr_i,
  output logic [ENT_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << IDX_W;

  logic [ENT_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/pkt_classify.sv
module pkt_classify
  import pcls_pkg::*;
#(
  parameter int DW           = 32,
  parameter int WIN          = 8,
  parameter int NF           = 8,
  parameter int PORT_W       = 2,
  parameter int COLOR_W      = 14,
  parameter int STREAM_W     = 2,
  parameter int FIFO_DEPTH   = 16,
  parameter int HDR_WORD     = 1,
  parameter int HDR_W        = 16,
  parameter int CFG_STRM_LSB = 16,
  localparam int IDX_W       = PORT_W + 2 + NF
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                in_valid_i,
  output logic                in_ready_o,
  input  logic                in_sop_i,
  input  logic                in_eop_i,
  input  logic [DW-1:0]       in_data_i,
  input  logic [PORT_W-1:0]   in_port_i,
  output logic                out_valid_o,
  input  logic                out_ready_i,
  output logic                out_sop_o,
  output logic                out_eop_o,
  output logic [DW-1:0]       out_data_o,
  output logic [STREAM_W-1:0] out_stream_o,
  input  logic                cfg_we_i,
  input  logic [1:0]          cfg_sel_i,
  input  logic [IDX_W-1:0]    cfg_addr_i,
  input  logic [DW-1:0]       cfg_wdata_i
);
  localparam int ENT_W = STREAM_W + 1 + COLOR_W;
  localparam int FA_W  = $clog2(NF) + $clog2(WIN);
  localparam int OC_W  = $clog2(HDR_WORD + 2);
  localparam int FW    = DW + 2;

  state_e                 st_q;
  logic                   eop_seen_q, drop_q;
  logic [COLOR_W-1:0]     color_q;
  logic [STREAM_W-1:0]    stream_q;
  logic [OC_W-1:0]        ocnt_q;
  logic [PORT_W-1:0]      port_q;
  logic                   acc, pop, win_done, ff_full, ff_empty;
  logic                   rd_sop, rd_eop;
  logic [DW-1:0]          rd_data;
  logic [FW-1:0]          ff_rdata;
  logic [WIN-1:0][DW-1:0] win;
  logic [IDX_W-1:0]       idx;
  logic [ENT_W-1:0]       ent, ent_wdata;
  logic                   flt_we, tbl_we;

  assign in_ready_o = !ff_full &&
                      (st_q == ST_COLLECT || (st_q == ST_FORWARD && !eop_seen_q));
  assign acc        = in_valid_i && in_ready_o;
  assign pop        = (st_q == ST_FORWARD) && !ff_empty && (drop_q || out_ready_i);

  assign flt_we    = cfg_we_i && (cfg_sel_i == CFG_FVAL || cfg_sel_i == CFG_FMASK);
  assign tbl_we    = cfg_we_i && (cfg_sel_i == CFG_TABLE);
  assign ent_wdata = {cfg_wdata_i[CFG_STRM_LSB +: STREAM_W], cfg_wdata_i[COLOR_W],
                      cfg_wdata_i[COLOR_W-1:0]};

  pcls_fifo #(.W(FW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (acc),
    .wdata_i ({in_sop_i, in_eop_i, in_data_i}),
    .pop_i   (pop),
    .rdata_o (ff_rdata),
    .full_o  (ff_full),
    .empty_o (ff_empty)
  );
  assign {rd_sop, rd_eop, rd_data} = ff_rdata;

  pcls_window #(.DW(DW), .WIN(WIN)) u_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .beat_i (acc),
    .sop_i  (in_sop_i),
    .eop_i  (in_eop_i),
    .data_i (in_data_i),
    .win_o  (win),
    .done_o (win_done)
  );

  pcls_match #(.DW(DW), .WIN(WIN), .NF(NF), .PORT_W(PORT_W)) u_match (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (flt_we),
    .is_mask_i (cfg_sel_i == CFG_FMASK),
    .addr_i    (cfg_addr_i[FA_W-1:0]),
    .wdata_i   (cfg_wdata_i),
    .win_i     (win),
    .port_i    (port_q),
    .idx_o     (idx)
  );

  pcls_table #(.IDX_W(IDX_W), .ENT_W(ENT_W)) u_tbl (
    .clk_i   (clk_i),
    .we_i    (tbl_we),
    .waddr_i (cfg_addr_i),
    .wdata_i (ent_wdata),
    .raddr_i (idx),
    .rdata_o (ent)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_COLLECT;
      eop_seen_q <= 1'b0;
      drop_q     <= 1'b0;
      color_q    <= '0;
      stream_q   <= '0;
      ocnt_q     <= '0;
      port_q     <= '0;
    end else begin
      if (acc && in_sop_i) port_q <= in_port_i;
      if (acc && in_eop_i)      eop_seen_q <= 1'b1;
      else if (pop && rd_eop)   eop_seen_q <= 1'b0;
      case (st_q)
        ST_COLLECT: if (acc && win_done) st_q <= ST_DECIDE;
        ST_DECIDE: begin
          // table read happens here, after the window is final
          color_q  <= ent[COLOR_W-1:0];
          drop_q   <= ent[COLOR_W];
          stream_q <= ent[ENT_W-1 -: STREAM_W];
          ocnt_q   <= '0;
          st_q     <= ST_FORWARD;
        end
        ST_FORWARD: if (pop) begin
          if (ocnt_q != OC_W'(HDR_WORD + 1)) ocnt_q <= ocnt_q + 1'b1;
          if (rd_eop) st_q <= ST_COLLECT;
        end
        default: st_q <= ST_COLLECT;
      endcase
    end
  end

  always_comb begin
    out_data_o = rd_data;
    if (ocnt_q == OC_W'(HDR_WORD)) out_data_o[HDR_W-1:0] = HDR_W'(color_q);
  end

  assign out_valid_o  = (st_q == ST_FORWARD) && !ff_empty && !drop_q;
  assign out_sop_o    = rd_sop;
  assign out_eop_o    = rd_eop;
  assign out_stream_o = stream_q;
endmodule

// File: rtl/pcls_checker.sv
module pcls_checker #(
  parameter int DW       = 32,
  parameter int STREAM_W = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                in_valid_i,
  input logic                in_ready_o,
  input logic                out_valid_o,
  input logic                out_ready_i,
  input logic                out_sop_o,
  input logic                out_eop_o,
  input logic [DW-1:0]       out_data_o,
  input logic [STREAM_W-1:0] out_stream_o
);
  logic [31:0]         in_cnt_q, out_cnt_q;
  logic                in_pkt_q;
  logic [STREAM_W-1:0] strm_q;
  logic                obeat;

  assign obeat = out_valid_o && out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_cnt_q  <= '0;
      out_cnt_q <= '0;
      in_pkt_q  <= 1'b0;
      strm_q    <= '0;
    end else begin
      if (in_valid_i && in_ready_o) in_cnt_q <= in_cnt_q + 1'b1;
      if (obeat) begin
        out_cnt_q <= out_cnt_q + 1'b1;
        if (out_sop_o) strm_q <= out_stream_o;
        in_pkt_q <= !out_eop_o;
      end
    end
  end

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o) &&
                                    $stable(out_stream_o) && $stable(out_sop_o));

  p_no_invent_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> out_cnt_q < in_cnt_q);

  p_sop_first_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !in_pkt_q |-> out_sop_o);

  p_no_sop_inside_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && in_pkt_q |-> !out_sop_o);

  p_stream_held_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && in_pkt_q |-> out_stream_o == strm_q);
endmodule

bind pkt_classify pcls_checker #(.DW(DW), .STREAM_W(STREAM_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .in_valid_i   (in_valid_i),
  .in_ready_o   (in_ready_o),
  .out_valid_o  (out_valid_o),
  .out_ready_i  (out_ready_i),
  .out_sop_o    (out_sop_o),
  .out_eop_o    (out_eop_o),
  .out_data_o   (out_data_o),
  .out_stream_o (out_stream_o)
);

// File: tb/sim_pkt_classify.sv
`timescale 1ns/1ps
module sim_pkt_classify;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0, in_sop_i = 1'b0, in_eop_i = 1'b0;
  logic [31:0] in_data_i = '0;
  logic [1:0]  in_port_i = '0;
  logic        in_ready_o, out_valid_o, out_sop_o, out_eop_o;
  logic        out_ready_i = 1'b1;
  logic [31:0] out_data_o;
  logic [1:0]  out_stream_o;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_sel_i = '0;
  logic [11:0] cfg_addr_i = '0;
  logic [31:0] cfg_wdata_i = '0;

  int checks = 0, errors = 0;
  int bp_mode = 0, bp_hold = 0, cyc = 0;

  logic [31:0] exp_data [1024];
  logic [1:0]  exp_strm [1024];
  logic        exp_sop [1024], exp_eop [1024], exp_hdr [1024];
  int          exp_n = 0;
  logic [31:0] got_data [1024];
  logic [1:0]  got_strm [1024];
  logic        got_sop [1024], got_eop [1024];
  int          got_n = 0;

  always #2.5 clk_i = ~clk_i;

  pkt_classify u0 (.*);

  typedef struct packed {
    logic [1:0]  port;
    logic [7:0]  len;
    logic [7:0]  hits;
    logic [1:0]  lb;
    logic        drop;
    logic [1:0]  strm;
    logic        bp;
    logic [11:0] exp_idx;  // {port, lb1, lb0, filters} after zero-padding
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{port:2'd0, len:8'd10, hits:8'hFF, lb:2'b00, drop:1'b0, strm:2'd0, bp:1'b0, exp_idx:12'h0FF},
    '{port:2'd1, len:8'd12, hits:8'h00, lb:2'b01, drop:1'b0, strm:2'd1, bp:1'b1, exp_idx:12'h500},
    '{port:2'd2, len:8'd9,  hits:8'hA5, lb:2'b10, drop:1'b1, strm:2'd2, bp:1'b0, exp_idx:12'hAA5},
    '{port:2'd3, len:8'd16, hits:8'h3C, lb:2'b11, drop:1'b0, strm:2'd3, bp:1'b1, exp_idx:12'hF3C},
    '{port:2'd0, len:8'd3,  hits:8'hFF, lb:2'b11, drop:1'b0, strm:2'd2, bp:1'b0, exp_idx:12'h007},
    '{port:2'd1, len:8'd1,  hits:8'h01, lb:2'b00, drop:1'b0, strm:2'd1, bp:1'b0, exp_idx:12'h401},
    '{port:2'd2, len:8'd2,  hits:8'h02, lb:2'b00, drop:1'b0, strm:2'd0, bp:1'b1, exp_idx:12'h802},
    '{port:2'd0, len:8'd8,  hits:8'h80, lb:2'b01, drop:1'b1, strm:2'd0, bp:1'b0, exp_idx:12'h180},
    '{port:2'd3, len:8'd6,  hits:8'h55, lb:2'b10, drop:1'b0, strm:2'd1, bp:1'b1, exp_idx:12'hE15},
    '{port:2'd1, len:8'd20, hits:8'h0F, lb:2'b11, drop:1'b0, strm:2'd3, bp:1'b1, exp_idx:12'h70F}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  // output ready pattern and monitor, both away from the rising edge
  initial forever begin
    @(negedge clk_i);
    cyc++;
    out_ready_i = (bp_hold != 0) ? 1'b0 : (bp_mode == 0) ? 1'b1 : (cyc[0] ^ cyc[2]);
  end

  initial forever begin
    @(negedge clk_i);
    #1;
    if (out_valid_o && out_ready_i && got_n < 1024) begin
      got_data[got_n] = out_data_o;
      got_strm[got_n] = out_stream_o;
      got_sop[got_n]  = out_sop_o;
      got_eop[got_n]  = out_eop_o;
      got_n++;
    end
  end

  task automatic cfg_write(input logic [1:0] sel, input logic [11:0] addr, input logic [31:0] data);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_addr_i = addr; cfg_wdata_i = data;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  function automatic logic [31:0] tbl_data(input logic [13:0] color, input logic drop, input logic [1:0] strm);
    return {14'd0, strm, 1'b0, drop, color};
  endfunction

  function automatic logic [31:0] mkword(input int vi, input int k, input logic [7:0] hits, input logic [1:0] lb);
    logic [31:0] w;
    logic        tgt;
    w = {1'b0, 7'(k + 5), 8'(vi), 8'(k), 8'hA5};
    if (k < 8 && hits[k]) w[7:0] = 8'(k);
    tgt = (k == 3) ? lb[0] : (k == 5) ? lb[1] : 1'b0;
    if ((k >= 3 && k <= 5) && (^w != tgt)) w[31] = 1'b1;
    return w;
  endfunction

  task automatic send_pkt(input int vi, input logic [1:0] port, input int len, input logic [7:0] hits,
                          input logic [1:0] lb, input logic drop, input logic [1:0] strm,
                          input logic [13:0] color, input int wr_at, input logic [11:0] wr_addr,
                          input logic [31:0] wr_data);
    for (int k = 0; k < len; k++) begin
      logic [31:0] w;
      w = mkword(vi, k, hits, lb);
      if (!drop) begin
        exp_data[exp_n] = (k == 1) ? {w[31:16], 2'b00, color} : w;
        exp_hdr[exp_n]  = (k == 1);
        exp_strm[exp_n] = strm;
        exp_sop[exp_n]  = (k == 0);
        exp_eop[exp_n]  = (k == len - 1);
        exp_n++;
      end
      @(negedge clk_i);
      cfg_we_i   = 1'b0;
      in_valid_i = 1'b1; in_sop_i = (k == 0); in_eop_i = (k == len - 1);
      in_data_i  = w; in_port_i = port;
      if (k == wr_at) begin
        cfg_we_i = 1'b1; cfg_sel_i = 2'd3; cfg_addr_i = wr_addr; cfg_wdata_i = wr_data;
      end
      #1;
      while (!in_ready_o) begin
        @(negedge clk_i);
        cfg_we_i = 1'b0;
        #1;
      end
    end
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    in_valid_i = 1'b0; in_sop_i = 1'b0; in_eop_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL R9: watchdog expired, actual hang expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    #1;
    chk(out_valid_o == 1'b0, "R1 out_valid in reset", 32'(out_valid_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    #1;
    chk(out_valid_o == 1'b0, "R1 out_valid after reset", 32'(out_valid_o), 32'd0);
    chk(in_ready_o == 1'b1, "R1 in_ready after reset", 32'(in_ready_o), 32'd1);

    // R2: filter f looks for low byte f in word f
    for (int f = 0; f < 8; f++) begin
      cfg_write(2'd1, 12'(f * 8 + f), 32'(f));
      cfg_write(2'd2, 12'(f * 8 + f), 32'h0000_00FF);
    end
    // R5: one entry per vector, color derived from the index
    for (int i = 0; i < NV; i++)
      cfg_write(2'd3, VEC[i].exp_idx, tbl_data({2'b10, VEC[i].exp_idx}, VEC[i].drop, VEC[i].strm));

    // vector walk: R2 R3 R4 R5 R6 R7 R8 R9 R11
    for (int i = 0; i < NV; i++) begin
      bp_mode = int'(VEC[i].bp);
      send_pkt(i, VEC[i].port, int'(VEC[i].len), VEC[i].hits, VEC[i].lb, VEC[i].drop,
               VEC[i].strm, {2'b10, VEC[i].exp_idx}, -1, '0, '0);
    end
    bp_mode = 0;
    repeat (60) @(negedge clk_i);

    // R10: table entry rewritten after the start word, before window completion
    cfg_write(2'd3, 12'h011, tbl_data(14'h0111, 1'b0, 2'd1));
    send_pkt(20, 2'd0, 10, 8'h11, 2'b00, 1'b0, 2'd2, 14'h1ABC, 2, 12'h011,
             tbl_data(14'h1ABC, 1'b0, 2'd2));
    repeat (40) @(negedge clk_i);

    // R9: long stall fills the FIFO
    cfg_write(2'd3, 12'h800, tbl_data(14'h2800, 1'b0, 2'd3));
    bp_hold = 1;
    fork
      send_pkt(21, 2'd2, 20, 8'h00, 2'b00, 1'b0, 2'd3, 14'h2800, -1, '0, '0);
    join_none
    repeat (40) @(negedge clk_i);
    #1;
    chk(in_ready_o == 1'b0, "R9 in_ready low with full FIFO", 32'(in_ready_o), 32'd0);
    chk(out_valid_o == 1'b1, "R9 output waiting under stall", 32'(out_valid_o), 32'd1);
    chk(out_sop_o == 1'b1, "R11 stalled head is start word", 32'(out_sop_o), 32'd1);
    bp_hold = 0;
    repeat (100) @(negedge clk_i);

    chk(got_n == exp_n, "R6 output beat count (dropped packets absent)", 32'(got_n), 32'(exp_n));
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      chk(got_data[i] == exp_data[i],
          exp_hdr[i] ? "R2/R3/R4/R5/R7/R10 header color word" : "R7/R9 payload word",
          got_data[i], exp_data[i]);
      chk(got_strm[i] == exp_strm[i], "R8 stream", 32'(got_strm[i]), 32'(exp_strm[i]));
      chk({got_sop[i], got_eop[i]} == {exp_sop[i], exp_eop[i]}, "R11 sop/eop framing",
          32'({got_sop[i], got_eop[i]}), 32'({exp_sop[i], exp_eop[i]}));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule